// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers that software loads through a simple write port, and turns a (segment, offset) request into a 20-bit physical address. The chosen base is moved up by four bit positions, so each base sits on a 16-byte boundary. The 16-bit offset is then added, and the sum is truncated to 20 bits. Every segment is therefore a 64 KB window into a 1 MB space. Windows from different registers may overlap or be disjoint.

Requests arrive on a valid/ready stream, and results leave on a second valid/ready stream through a one-entry output register. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its address appears on `pa` with `pa_valid` high from the next cycle. It stays there, unchanged, until a rising edge where `pa_ready` is high. The consumer applies back-pressure by holding `pa_ready` low. `req_ready` is high exactly when the output register is empty or is being drained in the same cycle, so a full, stalled stage refuses new requests.

The register write port is plain control: it takes effect on every edge where `seg_wr_en` is high, whatever the state of either stream.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset all four segment registers read 0000h, `pa_valid` is low and `req_ready` is high; a request then returns its own offset as the address.
- R2: A register written on an edge is used by requests accepted on later edges; a request accepted on the same edge as a write to its segment uses the value held before the write.
- R3: The select code on `req_sel` and `seg_wr_sel` picks the register as follows: 00 = extra, 01 = code, 10 = stack, 11 = data.
- R4: The address equals segment*16 + offset, taken modulo 2^20, so a sum above FFFFFh wraps to the bottom of the space.
- R5: `pa_valid` is high in the cycle after a request is accepted, and results leave in acceptance order.
- R6: While `pa_valid` is high and `pa_ready` is low, `pa` and `pa_valid` hold, and `req_ready` is low; otherwise `req_ready` is high.
- R7: A write changes only the selected register; the other three keep their values.
- R8: Bits 3:0 of each delivered address equal bits 3:0 of the offset of its request.
- R9: Register writes take effect while the output stream is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load the selected segment register |
| seg_wr_sel | input | 2 | Register to load (R3 encoding) |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_sel | input | 2 | Segment used by the request (R3 encoding) |
| req_offset | input | 16 | Offset within the segment |
| pa_valid | output | 1 | Physical address present |
| pa_ready | input | 1 | Consumer takes the address this cycle |
| pa | output | 20 | Physical address |

## Verification
Two functions can meet on the same edge: a segment register write and an accepted request that reads the same register. The bench drives a write and a request to one segment in a single cycle. It expects the pre-write base in that result and the new base in the request after it. A second collision happens while the output is stalled. A write issued during the stall must still land, and a request held against a full stage must not be taken until the consumer drains it. Both are judged against a bench-side register model that changes only after the edge.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_WIDTH   = 16;
  localparam int BASE_SHIFT  = 4;
  localparam int SEG_COUNT   = 4;

  typedef enum logic [1:0] {
    SEL_EXTRA = 2'b00,
    SEL_CODE  = 2'b01,
    SEL_STACK = 2'b10,
    SEL_DATA  = 2'b11
  } seg_sel_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  parameter int SEL_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_base
);
  logic [SEG_W-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)
        seg_q[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        seg_q[g] <= wr_data;
    end

    AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == SEL_W'(g))) |=> $stable(seg_q[g])); // R7
  end

  assign rd_base = seg_q[rd_sel];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data)); // R2
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] base,
  input  logic [SEG_W-1:0] offset,
  output logic [PA_W-1:0]  paddr
);
  logic [SEG_W-1:0] upper;

  // The low SHIFT bits of the base are zero, so only the upper part needs
  // an adder; its natural wrap gives the modulo-2^PA_W result.
  always_comb begin
    upper = base + SEG_W'(offset[SEG_W-1:SHIFT]);
    paddr = {upper, offset[SHIFT-1:0]};
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      dat_q <= in_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = SEG_WIDTH,
  parameter int SHIFT = BASE_SHIFT,
  parameter int NSEG  = SEG_COUNT,
  parameter int PA_W  = SEG_W + SHIFT,
  parameter int SEL_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [SEL_W-1:0] seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [SEG_W-1:0] req_offset,
  output logic             pa_valid,
  input  logic             pa_ready,
  output logic [PA_W-1:0]  pa
);
  logic [SEG_W-1:0] sel_base;
  logic [PA_W-1:0]  sum_addr;

  seg_bank #(.SEG_W(SEG_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .rd_sel  (req_sel),
    .rd_base (sel_base)
  );

  seg_addr_adder #(.SEG_W(SEG_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_add (
    .base   (sel_base),
    .offset (req_offset),
    .paddr  (sum_addr)
  );

  seg_out_stage #(.W(PA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (sum_addr),
    .out_valid (pa_valid),
    .out_ready (pa_ready),
    .out_data  (pa)
  );

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && !pa_ready) |-> !req_ready); // R6
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pa[SHIFT-1:0] == $past(req_offset[SHIFT-1:0]))); // R8
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic [15:0] req_offset = '0;
  logic        pa_valid;
  logic        pa_ready = 1'b0;
  logic [19:0] pa;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [19:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_offset(req_offset),
    .pa_valid(pa_valid), .pa_ready(pa_ready), .pa(pa)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // One cycle of stimulus; returns whether the request was taken.
  task automatic cycle(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                       input logic rv, input logic [1:0] rs, input logic [15:0] ro,
                       input logic rdy, input string tag, output bit taken);
    @(negedge clk);
    seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
    req_valid = rv; req_sel = rs; req_offset = ro; pa_ready = rdy;
    #(CLK_PERIOD/4);
    taken = rv && req_ready;
    if (taken) begin
      exp_q.push_back({model[rs], 4'h0} + {4'h0, ro});
      tag_q.push_back(tag);
    end
    if (we) model[ws] = wd;
  endtask

  task automatic send(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input logic [1:0] rs, input logic [15:0] ro, input string tag);
    bit taken = 0;
    bit first = 1;
    while (!taken) begin
      cycle(first ? we : 1'b0, ws, wd, 1'b1, rs, ro, 1'b1, tag, taken);
      first = 0;
    end
  endtask

  task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
    bit t;
    cycle(1'b1, ws, wd, 1'b0, 2'b00, 16'h0, 1'b1, "", t);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) cycle(1'b0, 2'b00, 16'h0, 1'b0, 2'b00, 16'h0, 1'b1, "", t);
  endtask

  // Monitor / scoreboard
  bit          prev_stall = 0;
  logic [19:0] prev_pa = '0;
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        check(req_ready === (!pa_valid || pa_ready), "R6 ready rule", {31'b0, req_ready}, {31'b0, (!pa_valid || pa_ready)});
        if (prev_stall)
          check(pa_valid === 1'b1 && pa === prev_pa, "R6 hold while stalled", {12'b0, pa}, {12'b0, prev_pa});
        prev_stall = pa_valid && !pa_ready;
        prev_pa = pa;
        if (pa_valid && pa_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected output", {12'b0, pa}, 32'h0);
          end else begin
            logic [19:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(pa === e, t, {12'b0, pa}, {12'b0, e});
            check(pa[3:0] === e[3:0], "R8 low nibble", {28'b0, pa[3:0]}, {28'b0, e[3:0]});
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit t;
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check(pa_valid === 1'b0, "R1 pa_valid after reset", {31'b0, pa_valid}, 32'h0);
    check(req_ready === 1'b1, "R1 req_ready after reset", {31'b0, req_ready}, 32'h1);

    // R1: reset bases are zero
    for (int s = 0; s < 4; s++) send(1'b0, 2'b00, 16'h0, 2'(s), 16'h1230 + 16'(s), "R1 zero base");
    idle(2);

    // R3 / R4: distinct bases, select encoding 00 ES 01 CS 10 SS 11 DS
    wr(2'b01, 16'h0009);
    wr(2'b11, 16'h0FFF);
    wr(2'b10, 16'h10E0);
    wr(2'b00, 16'h3281);
    send(1'b0, 2'b00, 16'h0, 2'b01, 16'h0000, "R3 code select");
    send(1'b0, 2'b00, 16'h0, 2'b11, 16'h0010, "R3 data select");
    send(1'b0, 2'b00, 16'h0, 2'b10, 16'hFFFF, "R3 stack select");
    send(1'b0, 2'b00, 16'h0, 2'b00, 16'h1234, "R3 extra select");
    send(1'b0, 2'b00, 16'h0, 2'b01, 16'hFF7F, "R4 overlap code/data");

    // R4 wrap
    wr(2'b11, 16'hFFFF);
    send(1'b0, 2'b00, 16'h0, 2'b11, 16'h0010, "R4 wrap to zero");
    send(1'b0, 2'b00, 16'h0, 2'b11, 16'hFFFF, "R4 wrap max");

    // R7: write extra only; code unchanged
    wr(2'b00, 16'h5555);
    send(1'b0, 2'b00, 16'h0, 2'b01, 16'h0004, "R7 code untouched");
    send(1'b0, 2'b00, 16'h0, 2'b00, 16'h0004, "R7 extra updated");

    // R2: write and request same segment same cycle -> old value; next -> new
    send(1'b1, 2'b10, 16'hABCD, 2'b10, 16'h0021, "R2 same-cycle old value");
    send(1'b0, 2'b00, 16'h0, 2'b10, 16'h0021, "R2 next-cycle new value");
    idle(2);

    // R6 / R9: stall the output, write during the stall
    cycle(1'b0, 2'b00, 16'h0, 1'b1, 2'b01, 16'h0001, 1'b0, "R6 first under stall", t);
    check(t, "R6 empty stage takes request", {31'b0, t}, 32'h1);
    cycle(1'b1, 2'b01, 16'h1234, 1'b1, 2'b10, 16'h0002, 1'b0, "R6 refused", t);
    check(!t, "R6 full stage refuses", {31'b0, t}, 32'h0);
    cycle(1'b0, 2'b00, 16'h0, 1'b1, 2'b10, 16'h0002, 1'b0, "R6 refused", t);
    check(!t, "R6 still refuses", {31'b0, t}, 32'h0);
    send(1'b0, 2'b00, 16'h0, 2'b10, 16'h0002, "R6 taken after drain");
    send(1'b0, 2'b00, 16'h0, 2'b01, 16'h0003, "R9 write during stall");
    idle(2);

    // Mixed traffic with random back-pressure
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] & lfsr[5], lfsr[2:1], {lfsr[7:0], lfsr[15:8]},
            lfsr[3] | lfsr[9], lfsr[11:10], lfsr ^ 16'h5A5A,
            lfsr[4] | lfsr[6], "R5 R4 mixed traffic", t);
    end
    idle(4);
    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule